// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block receives configuration words over a three-wire synchronous serial link: an active-low select, a serial clock and a data line. All three arrive without any timing relation to the system clock. They pass through multi-stage synchronizers, and their edges are detected in the system clock domain. While select is low, each rising serial clock edge shifts one data bit into a frame register. The first bit received is the least significant bit of the frame.

A frame is exactly sixteen bits. Its three lowest bits choose one of eight register addresses. The thirteen upper bits are the value for that register. Nothing is written when the sixteenth bit arrives. The write happens only when select rises, and only if exactly sixteen bits were counted. Short frames, over-long frames and writes to the four upper addresses leave every register unchanged. Besides the full register bank, the block drives a few control outputs decoded from fixed register fields: a gain code, sleep and standby enables, and an active-low soft reset.

Top module: `serial_cfg_port`

## Requirements
- R1: The hardware reset (rstN low) clears all four registers to zero. As a result, gainCode, sleepEn and standbyEn read 0, and softResetN reads 0, which means soft reset is asserted.
- R2: A frame is made of the data bits sampled on rising serial clock edges while select is low. The first bit is frame bit 0. Frame bits [2:0] give the address, and frame bits [15:3] are written to register `address`. Register k appears on regBank[13k+12:13k].
- R3: After the sixteenth serial clock edge, no output changes while select stays low. The write takes effect only after select rises.
- R4: A frame that ends after fewer than sixteen serial clock edges, including zero edges, changes no register.
- R5: A frame with more than sixteen serial clock edges changes no register.
- R6: A complete frame whose address is 4, 5, 6 or 7 changes no register.
- R7: gainCode equals register 0 bits [12:5], which are frame bits [15:8] of the last write to address 0.
- R8: sleepEn equals register 1 bit 0 (frame bit 3). standbyEn equals register 1 bit 1 (frame bit 4). Both are active high.
- R9: softResetN equals register 2 bit 12 (frame bit 15). A value of 0 means reset mode.
- R10: Frames sent back to back are each handled on their own. The bit count restarts at every falling edge of select, so a rejected frame does not affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| csN | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, sampled on rising sclk |
| regBank | output | 52 | Four 13-bit registers, register 0 in the low bits |
| gainCode | output | 8 | Gain code field of register 0 |
| sleepEn | output | 1 | Sleep enable, active high |
| standbyEn | output | 1 | Standby enable, active high |
| softResetN | output | 1 | Soft reset, active low |

## Verification
The hardest state to reach from the ports is the pending state. In that state a complete frame has been shifted in, but select has not yet risen. The bench stops right after the sixteenth edge, holds select low for many system cycles and checks that nothing has moved. Only then does it release select. Frame length is swept from zero to twenty edges, so the boundary on each side of sixteen is exercised. Every address, reserved ones included, is written with several computed payloads, and each result is compared against a model of the register bank kept in the bench.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic shiftEn;  // capture one data bit
    logic clear;    // start of a new frame
    logic commit;   // complete frame ended by select rising
  } scfg_strobe_t;
endpackage

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdiS,
  output scfg_strobe_t strb
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] OVER = CW'(FRAME_BITS + 1);

  logic [2:0] syncPipe [SYNC_STAGES];
  logic csS, sclkS, csPrev, sclkPrev;
  logic [CW-1:0] bitCount;
  logic csRise, csFall, sclkRise;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[s] <= 3'b100;
        else       syncPipe[s] <= {csN, sclk, sdi};
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[s] <= 3'b100;
        else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign csS   = syncPipe[SYNC_STAGES-1][2];
  assign sclkS = syncPipe[SYNC_STAGES-1][1];
  assign sdiS  = syncPipe[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csRise   = csS & ~csPrev;
  assign csFall   = ~csS & csPrev;
  assign sclkRise = sclkS & ~sclkPrev;

  always_comb begin
    strb.clear   = csFall;
    strb.shiftEn = sclkRise & ~csS & ~csPrev;
    strb.commit  = csRise & (bitCount == FULL);
  end

  // Saturating edge counter; OVER marks an over-long frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               bitCount <= '0;
    else if (strb.clear)                     bitCount <= '0;
    else if (strb.shiftEn && bitCount != OVER) bitCount <= bitCount + 1'b1;
  end
endmodule

// File: rtl/scfg_datapath.sv
module scfg_datapath
  import scfg_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_BITS  = 3,
  parameter int NUM_REGS   = 4,
  parameter int GAIN_BITS  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sdiS,
  input  scfg_strobe_t                     strb,
  output logic [FRAME_BITS-1:0]            shiftReg,
  output logic [NUM_REGS*(FRAME_BITS-ADDR_BITS)-1:0] regBank,
  output logic [GAIN_BITS-1:0]             gainCode,
  output logic                             sleepEn,
  output logic                             standbyEn,
  output logic                             softResetN
);
  localparam int PAY = FRAME_BITS - ADDR_BITS;

  logic [ADDR_BITS-1:0] addrField;
  logic [PAY-1:0]       payload;
  logic [PAY-1:0]       regArr [NUM_REGS];

  // LSB arrives first: shift in from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.clear)   shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {sdiS, shiftReg[FRAME_BITS-1:1]};
  end

  assign addrField = shiftReg[ADDR_BITS-1:0];
  assign payload   = shiftReg[FRAME_BITS-1:ADDR_BITS];

  // Only addresses below NUM_REGS get a write enable
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regArr[g] <= '0;
      else if (strb.commit && addrField == ADDR_BITS'(g)) regArr[g] <= payload;
    end
    assign regBank[g*PAY +: PAY] = regArr[g];
  end

  assign gainCode   = regArr[0][PAY-1 -: GAIN_BITS];
  assign sleepEn    = regArr[1][0];
  assign standbyEn  = regArr[1][1];
  assign softResetN = regArr[2][PAY-1];
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scfg_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int ADDR_BITS   = 3,
  parameter int NUM_REGS    = 4,
  parameter int GAIN_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        csN,
  input  logic                                        sclk,
  input  logic                                        sdi,
  output logic [NUM_REGS*(FRAME_BITS-ADDR_BITS)-1:0]  regBank,
  output logic [GAIN_BITS-1:0]                        gainCode,
  output logic                                        sleepEn,
  output logic                                        standbyEn,
  output logic                                        softResetN
);
  scfg_strobe_t          strb;
  logic                  sdiS;
  logic [FRAME_BITS-1:0] shiftReg;

  scfg_ctrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdiS(sdiS), .strb(strb)
  );

  scfg_datapath #(.FRAME_BITS(FRAME_BITS), .ADDR_BITS(ADDR_BITS),
                  .NUM_REGS(NUM_REGS), .GAIN_BITS(GAIN_BITS)) dpath (
    .clk(clk), .rstN(rstN), .sdiS(sdiS), .strb(strb), .shiftReg(shiftReg),
    .regBank(regBank), .gainCode(gainCode), .sleepEn(sleepEn),
    .standbyEn(standbyEn), .softResetN(softResetN)
  );
endmodule

// File: rtl/scfg_chk.sv
module scfg_chk
  import scfg_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_BITS  = 3,
  parameter int NUM_REGS   = 4
) (
  input logic                                        clk,
  input logic                                        rstN,
  input scfg_strobe_t                                strb,
  input logic [FRAME_BITS-1:0]                       shiftReg,
  input logic [NUM_REGS*(FRAME_BITS-ADDR_BITS)-1:0]  regBank
);
  localparam int PAY = FRAME_BITS - ADDR_BITS;
  localparam logic [ADDR_BITS-1:0] LIMIT = ADDR_BITS'(NUM_REGS);

  logic [ADDR_BITS-1:0] addrNow;
  logic [PAY-1:0]       payNow;
  assign addrNow = shiftReg[ADDR_BITS-1:0];
  assign payNow  = shiftReg[FRAME_BITS-1:ADDR_BITS];

  // R2
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && addrNow < LIMIT |=>
      regBank[int'($past(addrNow))*PAY +: PAY] == $past(payNow));

  // R6
  reserved_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && addrNow >= LIMIT |=> $stable(regBank));

  // R3
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(regBank));

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn && !strb.clear |=> $stable(shiftReg));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftEn, strb.clear, strb.commit}));
endmodule

bind serial_cfg_port scfg_chk #(
  .FRAME_BITS(FRAME_BITS), .ADDR_BITS(ADDR_BITS), .NUM_REGS(NUM_REGS)
) chkInst (
  .clk(clk), .rstN(rstN), .strb(strb), .shiftReg(shiftReg), .regBank(regBank)
);

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
module serial_cfg_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [51:0] regBank;
  logic [7:0]  gainCode;
  logic sleepEn, standbyEn, softResetN;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [12:0] expReg [4];

  always #5 clk = ~clk;

  serial_cfg_port uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .regBank(regBank), .gainCode(gainCode), .sleepEn(sleepEn),
    .standbyEn(standbyEn), .softResetN(softResetN)
  );

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic [51:0] flat;
    for (int k = 0; k < 4; k++) flat[k*13 +: 13] = expReg[k];
    cmp(req, 64'(regBank), 64'(flat));
    cmp("R7 gain", 64'(gainCode), 64'(expReg[0] >> 5));
    cmp("R8 sleep", 64'(sleepEn), 64'(expReg[1] % 2));
    cmp("R8 standby", 64'(standbyEn), 64'((expReg[1] / 2) % 2));
    cmp("R9 softReset", 64'(softResetN), 64'(expReg[2] / 4096));
  endtask

  task automatic lowerCs();
    @(negedge clk); csN = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic sendBits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = w[i % 16];
      repeat (5) @(negedge clk); sclk = 1'b1;
      repeat (5) @(negedge clk); sclk = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic raiseCs();
    csN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [15:0] w, input int n);
    lowerCs();
    sendBits(w, n);
    raiseCs();
    if (n == 16 && w[2:0] < 3'd4) expReg[w[2:0]] = w[15:3];
  endtask

  task automatic hwReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 4; k++) expReg[k] = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [12:0] pay;
    hwReset();
    checkAll("R1 reset");

    // R2 R6: every address with computed payloads; reserved ones must not move
    for (int a = 0; a < 8; a++) begin
      for (int p = 0; p < 6; p++) begin
        pay = (p == 0) ? 13'h0000 : (p == 1) ? 13'h1FFF
            : 13'((32'h0A5B * p) ^ (a << p));
        sendFrame({pay, 3'(a)}, 16);
        checkAll(a < 4 ? "R2 write" : "R6 reserved");
      end
    end

    // R7 R8 R9: walking one through each decoded register
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < 13; b++) begin
        sendFrame({13'(1 << b), 3'(r)}, 16);
        checkAll(r == 0 ? "R7 walk" : r == 1 ? "R8 walk" : "R9 walk");
      end
    end

    // R4: short frames 0..15 edges
    for (int n = 0; n < 16; n++) begin
      sendFrame({13'h1ABC ^ 13'(n), 3'(n % 4)}, n);
      checkAll("R4 short");
    end

    // R5: over-long frames
    for (int n = 17; n < 21; n++) begin
      sendFrame({13'h0F0F ^ 13'(n), 3'(n % 4)}, n);
      checkAll("R5 long");
    end

    // R3: pending frame held with select low
    lowerCs();
    sendBits({13'h1357, 3'd1}, 16);
    repeat (40) @(negedge clk);
    checkAll("R3 pending");
    raiseCs();
    expReg[1] = 13'h1357;
    checkAll("R3 after rise");

    // R10: rejected frame directly followed by a good one
    sendFrame({13'h0777, 3'd3}, 9);
    sendFrame({13'h1BAD, 3'd3}, 16);
    checkAll("R10 back to back");
    sendFrame({13'h0123, 3'd0}, 19);
    sendFrame({13'h1E01, 3'd0}, 16);
    checkAll("R10 after long");

    // R1: reset after writes
    hwReset();
    checkAll("R1 reset again");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule